// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block collects interrupt events from five sources of a small microcontroller core and turns them into a single request to the CPU. The sources are two external pins, two timer overflow events and a serial port event. Each event is latched in a pending flag. The request is gated by a global enable and by one enable per source. It carries a vector index that names the source chosen.

Software places each source on one of two levels through a priority register. Ties within a level are broken by a fixed scan order. The arbiter tracks which levels currently have a handler running, so a high-level request can interrupt a low-level handler. Requests at the same or a lower level wait. Software can also set pending flags directly, which raises an interrupt exactly as a hardware event would. The CPU answers a request with an acknowledge strobe and ends each handler with a return strobe.

Top module: `irq_arbiter`

## Requirements
- R1: A synchronous reset clears every pending flag, every enable bit, the priority register and both in-service bits, and holds `irq_req` low.
- R2: An external pin passes through a two-flop synchronizer. A high-to-low transition sets its pending flag (pin 0 is source 0, pin 1 is source 2). A rising edge or a steady low level sets nothing.
- R3: A one-cycle pulse on `tmr_evt[0]`, `tmr_evt[1]` or `ser_evt` sets the pending flag of source 1, 3 or 4 respectively.
- R4: A write with `cfg_sel`=0 loads the enables. Bit i enables source i, and bit 5 is the global enable. A pending source is offered only when its bit and the global bit are both 1. A disabled flag stays latched and is offered once it is enabled.
- R5: Among eligible sources of the same level, the lowest index wins. The scan order is external 0, timer 0, external 1, timer 1, serial, and `irq_vec` gives that index (0 to 4).
- R6: A write with `cfg_sel`=1 loads the priority bits, where bit i puts source i on the high level. Any eligible high-level source beats every low-level source. For example, the value 5'b01100 puts external 1 and timer 1 on the high level.
- R7: `cpu_ack` while `irq_req` is high clears the pending flag of the offered vector and marks its level as in service. `irq_req` is low in the following cycle.
- R8: While a low-level handler is in service, only high-level sources are offered. While a high-level handler is in service, nothing is offered.
- R9: `cpu_reti` clears the high in-service bit if it is set, and otherwise clears the low one.
- R10: A write with `cfg_sel`=2 sets the pending flags whose data bits are 1. Flags whose data bits are 0 are left unchanged. Forced flags behave like hardware events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_n | input | 2 | External interrupt pins, active low, asynchronous |
| tmr_evt | input | 2 | Timer 0 / timer 1 event pulses |
| ser_evt | input | 1 | Serial port event pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 enables, 1 priority, 2 force pending |
| cfg_wdata | input | 6 | Write data, bit i = source i, bit 5 = global enable |
| cpu_ack | input | 1 | CPU accepts the offered vector |
| cpu_reti | input | 1 | CPU ends the current handler |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | 3 | Registered vector index of the request |
| irq_hi | output | 1 | Request belongs to the high level |

## Verification
The assertions assume that the CPU raises `cpu_ack` only in a cycle where `irq_req` is high. They also assume that acknowledge and return never fall in the same cycle, and that a return is issued only while some level is in service. The stimulus acknowledges only after it has seen the request at the outputs. It issues returns only while its own model holds a level in service, and it applies one operation at a time with idle cycles between them. Any pin or event change therefore settles before the next strobe.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned NSRC     = 5;
  localparam int unsigned VEC_W    = $clog2(NSRC);
  localparam int unsigned CFG_W    = NSRC + 1;
  localparam int unsigned GLOB_BIT = NSRC;
  localparam int unsigned NEXT     = 2;

  localparam int unsigned SRC_EXT0 = 0;
  localparam int unsigned SRC_TMR0 = 1;
  localparam int unsigned SRC_EXT1 = 2;
  localparam int unsigned SRC_TMR1 = 3;
  localparam int unsigned SRC_SER  = 4;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_PRIO   = 2'd1,
    SEL_FORCE  = 2'd2,
    SEL_NONE   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[STAGES-1:0], pin_n};
  end

  // previous synchronized level high, current synchronized level low
  assign fall = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N = 5,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] sw_set,
  input  logic         clr_en,
  input  logic [W-1:0] clr_idx,
  output logic [N-1:0] pend
);
  logic [N-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (clr_en) clr_mask = N'(1) << clr_idx;
  end

  // a new event in the same cycle as the clear wins
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_mask) | hw_set | sw_set;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N = 5,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] cand,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
  input  logic       clk,
  input  logic       rst,
  input  logic       ack,
  input  logic       ack_hi,
  input  logic       reti,
  output logic [1:0] isr
);
  logic [1:0] isr_nxt;

  always_comb begin
    isr_nxt = isr;
    if (reti) begin
      if (isr_nxt[1]) isr_nxt[1] = 1'b0;
      else            isr_nxt[0] = 1'b0;
    end
    if (ack) begin
      if (ack_hi) isr_nxt[1] = 1'b1;
      else        isr_nxt[0] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) isr <= '0;
    else     isr <= isr_nxt;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NEXT-1:0]  ext_n,
  input  logic [1:0]       tmr_evt,
  input  logic             ser_evt,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             cpu_ack,
  input  logic             cpu_reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_hi
);
  localparam int unsigned EXT_SRC [NEXT] = '{SRC_EXT0, SRC_EXT1};

  logic [NEXT-1:0]  ext_fall;
  logic [NSRC-1:0]  hw_set, sw_set, pend;
  logic [NSRC-1:0]  en_q, prio_q;
  logic             glob_q;
  logic [1:0]       isr_q;
  logic [NSRC-1:0]  elig, hi_cand, lo_cand;
  logic             hi_found, lo_found;
  logic [VEC_W-1:0] hi_idx, lo_idx;
  logic             grant_ok, grant_hi;
  logic [VEC_W-1:0] grant_idx;
  logic             ack_ok;
  cfg_sel_e         sel;

  assign sel = cfg_sel_e'(cfg_sel);

  // external pins: synchronizer and falling-edge detect per pin
  for (genvar g = 0; g < NEXT; g++) begin : g_ext
    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .pin_n (ext_n[g]),
      .fall  (ext_fall[g])
    );
  end

  always_comb begin
    hw_set = '0;
    for (int i = 0; i < NEXT; i++) hw_set[EXT_SRC[i]] = ext_fall[i];
    hw_set[SRC_TMR0] = tmr_evt[0];
    hw_set[SRC_TMR1] = tmr_evt[1];
    hw_set[SRC_SER]  = ser_evt;
  end

  assign sw_set = (cfg_we && sel == SEL_FORCE) ? cfg_wdata[NSRC-1:0] : '0;
  assign ack_ok = cpu_ack & irq_req;

  irq_pend_bank #(.N(NSRC)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .hw_set  (hw_set),
    .sw_set  (sw_set),
    .clr_en  (ack_ok),
    .clr_idx (irq_vec),
    .pend    (pend)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      glob_q <= 1'b0;
      prio_q <= '0;
    end else if (cfg_we) begin
      case (sel)
        SEL_ENABLE: begin
          en_q   <= cfg_wdata[NSRC-1:0];
          glob_q <= cfg_wdata[GLOB_BIT];
        end
        SEL_PRIO: prio_q <= cfg_wdata[NSRC-1:0];
        default: ;
      endcase
    end
  end

  irq_svc_track u_svc (
    .clk    (clk),
    .rst    (rst),
    .ack    (ack_ok),
    .ack_hi (irq_hi),
    .reti   (cpu_reti),
    .isr    (isr_q)
  );

  // arbitration: level first, then fixed scan order
  assign elig    = pend & en_q & {NSRC{glob_q}};
  assign hi_cand = elig & prio_q;
  assign lo_cand = elig & ~prio_q;

  irq_prio_pick #(.N(NSRC)) u_pick_hi (
    .cand (hi_cand), .found (hi_found), .idx (hi_idx)
  );
  irq_prio_pick #(.N(NSRC)) u_pick_lo (
    .cand (lo_cand), .found (lo_found), .idx (lo_idx)
  );

  always_comb begin
    grant_ok  = 1'b0;
    grant_hi  = 1'b0;
    grant_idx = '0;
    if (hi_found && !isr_q[1]) begin
      grant_ok  = 1'b1;
      grant_hi  = 1'b1;
      grant_idx = hi_idx;
    end else if (lo_found && isr_q == 2'b00) begin
      grant_ok  = 1'b1;
      grant_idx = lo_idx;
    end
  end

  // registered outputs; an acknowledge drops the request for one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      irq_hi  <= 1'b0;
    end else begin
      irq_req <= grant_ok & ~cpu_ack;
      irq_vec <= grant_idx;
      irq_hi  <= grant_hi;
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_arb_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cpu_ack,
  input logic             cpu_reti,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic             irq_hi,
  input logic [1:0]       isr_q,
  input logic [NSRC-1:0]  en_q,
  input logic             glob_q
);
  logic [NSRC-1:0] en_d;
  logic            glob_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d   <= '0;
      glob_d <= 1'b0;
    end else begin
      en_d   <= en_q;
      glob_d <= glob_q;
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_req && isr_q == 2'b00));

  a_r4_req_only_enabled: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !$past(rst)) |-> (glob_d && en_d[irq_vec]));

  a_r5_vec_in_range: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (int'(irq_vec) < NSRC));

  a_r7_ack_drops_req: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !irq_req);

  a_r7_ack_marks_level: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && irq_req && !cpu_reti) |=> isr_q[$past(irq_hi)]);

  a_r8_hi_blocks_all: assert property (@(posedge clk) disable iff (rst)
    isr_q[1] |-> !irq_req);

  a_r8_lo_allows_only_hi: assert property (@(posedge clk) disable iff (rst)
    (isr_q[0] && irq_req) |-> irq_hi);

  a_r9_reti_pops_hi: assert property (@(posedge clk) disable iff (rst)
    (cpu_reti && !cpu_ack && isr_q == 2'b11) |=> isr_q == 2'b01);

  a_r9_reti_pops_lo: assert property (@(posedge clk) disable iff (rst)
    (cpu_reti && !cpu_ack && isr_q == 2'b01) |=> isr_q == 2'b00);
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpu_ack  (cpu_ack),
  .cpu_reti (cpu_reti),
  .irq_req  (irq_req),
  .irq_vec  (irq_vec),
  .irq_hi   (irq_hi),
  .isr_q    (isr_q),
  .en_q     (en_q),
  .glob_q   (glob_q)
);

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ext_n = 2'b11;
  logic [1:0] tmr_evt = 2'b00;
  logic       ser_evt = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd3;
  logic [5:0] cfg_wdata = '0;
  logic       cpu_ack = 1'b0;
  logic       cpu_reti = 1'b0;
  logic       irq_req;
  logic [2:0] irq_vec;
  logic       irq_hi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [4:0] m_pend = '0, m_en = '0, m_prio = '0;
  logic       m_glob = 1'b0;
  logic [1:0] m_isr = '0;

  always #5 clk = ~clk;

  irq_arbiter i_irq_arbiter (
    .clk(clk), .rst(rst), .ext_n(ext_n), .tmr_evt(tmr_evt), .ser_evt(ser_evt),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cpu_ack(cpu_ack), .cpu_reti(cpu_reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_hi(irq_hi)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model_pick(output bit v, output int idx);
    logic [4:0] e;
    v = 0; idx = 0;
    e = m_pend & m_en & {5{m_glob}};
    if (!m_isr[1]) begin
      for (int i = 4; i >= 0; i--) if (e[i] && m_prio[i]) begin v = 1; idx = i; end
    end
    if (!v && m_isr == 2'b00) begin
      for (int i = 4; i >= 0; i--) if (e[i] && !m_prio[i]) begin v = 1; idx = i; end
    end
  endfunction

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic compare(input string tag);
    bit v; int idx;
    model_pick(v, idx);
    check(irq_req == v, {tag, " req"}, int'(irq_req), int'(v));
    if (v) check(int'(irq_vec) == idx, {tag, " vec"}, int'(irq_vec), idx);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [5:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd3;
    case (sel)
      2'd0: begin m_en = d[4:0]; m_glob = d[5]; end
      2'd1: m_prio = d[4:0];
      2'd2: m_pend = m_pend | d[4:0];
      default: ;
    endcase
    settle();
  endtask

  task automatic fire(input int s);
    @(negedge clk);
    case (s)
      0: ext_n[0] = 1'b0;
      2: ext_n[1] = 1'b0;
      1: tmr_evt[0] = 1'b1;
      3: tmr_evt[1] = 1'b1;
      default: ser_evt = 1'b1;
    endcase
    @(negedge clk);
    tmr_evt = 2'b00; ser_evt = 1'b0;
    repeat (4) @(negedge clk);
    ext_n = 2'b11;
    m_pend[s] = 1'b1;
    settle();
  endtask

  task automatic do_ack();
    bit v; int idx;
    model_pick(v, idx);
    @(negedge clk);
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
    check(irq_req == 1'b0, "R7 req low after ack", int'(irq_req), 0);
    if (v) begin
      m_pend[idx] = 1'b0;
      m_isr[m_prio[idx] ? 1 : 0] = 1'b1;
    end
    settle();
  endtask

  task automatic do_reti();
    @(negedge clk);
    cpu_reti = 1'b1;
    @(negedge clk);
    cpu_reti = 1'b0;
    if (m_isr[1]) m_isr[1] = 1'b0;
    else          m_isr[0] = 1'b0;
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(irq_req == 1'b0, "R1 no request after reset", int'(irq_req), 0);

    // R3 with all enables clear: latched but not offered (R4)
    fire(1);
    check(irq_req == 1'b0, "R4 disabled source silent", int'(irq_req), 0);
    cfg_write(2'd0, 6'b011111);
    check(irq_req == 1'b0, "R4 global enable clear", int'(irq_req), 0);
    cfg_write(2'd0, 6'b111101);
    check(irq_req == 1'b0, "R4 source bit clear", int'(irq_req), 0);
    cfg_write(2'd0, 6'b111111);
    compare("R4 latched flag offered once enabled");
    check(irq_vec == 3'd1, "R3 timer0 vector", int'(irq_vec), 1);
    do_ack();
    compare("R7 pending cleared");
    do_reti();

    // R2 external edge, then rising edge ignored
    fire(0);
    compare("R2 ext0 falling edge");
    do_ack(); do_reti();
    @(negedge clk); ext_n[0] = 1'b0; settle();
    do_ack(); do_reti();
    ext_n[0] = 1'b1; settle();
    check(irq_req == 1'b0, "R2 rising edge ignored", int'(irq_req), 0);

    // R5 / R10 forced tie, all low
    cfg_write(2'd2, 6'b011111);
    compare("R10 forced flags");
    check(irq_vec == 3'd0, "R5 lowest index wins", int'(irq_vec), 0);
    do_ack();
    check(irq_req == 1'b0, "R8 low does not preempt low", int'(irq_req), 0);
    cfg_write(2'd1, 6'b001100);
    compare("R6 high preempts low handler");
    check(irq_vec == 3'd2, "R6 ext1 high first", int'(irq_vec), 2);
    do_ack();
    check(irq_req == 1'b0, "R8 nothing preempts high", int'(irq_req), 0);
    do_reti();
    compare("R9 high popped first");
    check(irq_vec == 3'd3, "R6 timer1 next", int'(irq_vec), 3);
    do_ack(); do_reti();
    compare("R9 still in low handler");
    do_reti();
    compare("R9 low popped");
    check(irq_vec == 3'd1, "R5 timer0 after pops", int'(irq_vec), 1);

    // random phase
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1, 2: fire(int'($urandom_range(0, 4)));
        3: cfg_write(2'd2, {1'b0, 5'($urandom)});
        4: cfg_write(2'd1, {1'b0, 5'($urandom)});
        5: cfg_write(2'd0, ($urandom_range(0, 3) == 0) ? 6'($urandom) : {1'b1, 5'($urandom)});
        6, 7: if (irq_req) do_ack();
        default: if (m_isr != 2'b00) do_reti();
      endcase
      compare("R5 random arbitration");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule